// File: doc/BRIEF.md
# Serial Bit-Clock Router with Transmit Divider

This block selects the receive and transmit bit clocks of a synchronous serial channel. Every clock is represented as a single-cycle enable in one system clock domain. There are four candidate sources:

- two external clock pins (pin A, and a bidirectional pin B);
- the baud-rate generator tick;
- a phase-locked-loop path.

On the receive side, the phase-locked-loop path is the loop's own recovered receive tick.

On the transmit side, that path is a free-running divider that counts ticks of the reference clock feeding the phase-locked loop. The divider has no phase adjustment, so it gives a transmitter clock without jitter. Its ratio follows the line-coding mode.

A clock-mode control word sets the two source selections and the direction of pin B. When pin B is an output, the same word also chooses which internal clock pin B carries. One choice is the recovered receive tick, so that a loop configuration can clock both directions from one clock.

The external pins are synchronized and edge-detected before use.

Top module: `sclk_route`

## Requirements
- R1: Control bits 6:5 select the receive clock enable. 00 selects pin A, 01 selects pin B, 10 selects the baud-rate tick and 11 selects the recovered receive tick. A non-pin source reaches `rx_clk_en` in the same cycle.
- R2: Control bits 4:3 select the transmit clock enable with the same codes: 00 pin A, 01 pin B, 10 baud-rate tick, 11 divider output. A non-pin source reaches `tx_clk_en` in the same cycle.
- R3: With `enc_sel[1]` = 1 (the two biphase codes 10 and 11), the divider pulses once on every 16th reference tick. The pulse comes in the same cycle as that tick.
- R4: With `enc_sel[1]` = 0 (codes 00 inverted-level and 01 plain level), the divider pulses once on every 32nd reference tick.
- R5: The recovered receive tick selected by code 11 of bits 6:5 is passed to `rx_clk_en` unchanged, whatever the divider is doing.
- R6: Control bit 2 drives `clkpin_b_oe`, where 1 means output. While it is 1, pin B never produces a receive or transmit enable.
- R7: When bit 2 is 1, control bits 1:0 choose what `clkpin_b_out` carries: 00 the chosen transmit enable, 01 the chosen receive enable, 10 the baud-rate tick, 11 the recovered receive tick.
- R8: A rising level on a clock pin gives exactly one enable cycle. The level is sampled at a clock edge, and the enable is high in the cycle that follows the second clock edge after that sample. A held high level gives no further enables.
- R9: Any change of `enc_sel` clears the divider count. The cycle in which the change is seen gives no pulse, and counting then restarts from zero.
- R10: After reset all outputs are 0 and the divider count is zero, so the first divider pulse comes on the full-ratio tick.
- R11: While bit 2 is 0, `clkpin_b_out` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clkpin_a_in | input | 1 | Level on external clock pin A |
| clkpin_b_in | input | 1 | Level seen on bidirectional clock pin B |
| brg_tick | input | 1 | Baud-rate generator enable |
| dpll_rx_tick | input | 1 | Recovered receive enable from the phase-locked loop |
| dpll_ref_tick | input | 1 | Enable of the clock that drives the phase-locked loop |
| cmode | input | 7 | Clock-mode control: 6:5 receive source, 4:3 transmit source, 2 pin B direction, 1:0 pin B output source |
| enc_sel | input | 2 | Line coding: 00 inverted-level, 01 level, 10/11 biphase |
| rx_clk_en | output | 1 | Chosen receive clock enable |
| tx_clk_en | output | 1 | Chosen transmit clock enable |
| clkpin_b_out | output | 1 | Value driven on pin B |
| clkpin_b_oe | output | 1 | Pin B output enable |

## Verification
Enables from the baud-rate generator and the phase-locked loop are combinational, so they are due in the cycle they are applied. The divider pulse is due in the cycle of the 16th or 32nd reference tick. A pin edge is due two clock edges after the level change, and the cycle after that must be low again. The driver pushes each expectation with its absolute due cycle into a scoreboard queue. The monitor samples a quarter period before each rising edge, when the inputs driven at the falling edge and the state from the last rising edge have both settled, and it checks exactly the items that fall due in that cycle.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

  // Source codes shared by the receive and transmit select fields.
  typedef enum logic [1:0] {
    SRC_PIN_A = 2'b00,
    SRC_PIN_B = 2'b01,
    SRC_BRG   = 2'b10,
    SRC_PLL   = 2'b11
  } src_e;

  // Codes for what pin B drives when it is an output.
  typedef enum logic [1:0] {
    PB_TX     = 2'b00,
    PB_RX     = 2'b01,
    PB_BRG    = 2'b10,
    PB_PLL_RX = 2'b11
  } pbsel_e;

  // Field positions inside the clock-mode word.
  localparam int CM_RX_HI = 6;
  localparam int CM_RX_LO = 5;
  localparam int CM_TX_HI = 4;
  localparam int CM_TX_LO = 3;
  localparam int CM_OE    = 2;
  localparam int CM_PB_HI = 1;
  localparam int CM_PB_LO = 0;

  // Four-way pick. srcs[0] holds code 00 and srcs[3] holds code 11.
  function automatic logic pick4(input logic [1:0] sel, input logic [3:0] srcs);
    return srcs[sel];
  endfunction

  // Divider ratio. Biphase codings use the short ratio, level codings the long one.
  function automatic int unsigned div_ratio(input logic biphase,
                                            input int unsigned fm_div,
                                            input int unsigned lvl_div);
    return biphase ? fm_div : lvl_div;
  endfunction

endpackage

// File: rtl/sclk_edge_sync.sv
module sclk_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_lvl,
  output logic rise
);

  logic [STAGES-1:0] shreg;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= pin_lvl;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[STAGES-2:0], pin_lvl};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= shreg[STAGES-1];
  end

  assign rise = shreg[STAGES-1] & ~last_q;

endmodule

// File: rtl/sclk_txdiv.sv
module sclk_txdiv
  import sclk_pkg::*;
#(
  parameter int DIV_FM  = 16,
  parameter int DIV_LVL = 32,
  parameter int CW      = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    enc_sel,
  input  logic          ref_tick,
  output logic          div_tick,
  output logic          enc_chg,
  output logic [CW-1:0] cnt
);

  logic [1:0]    enc_q;
  logic [CW-1:0] lim;
  logic          at_lim;

  always_comb begin
    lim    = CW'(div_ratio(enc_sel[1], DIV_FM, DIV_LVL) - 1);
    at_lim = (cnt == lim);
  end

  assign enc_chg  = (enc_sel != enc_q);
  assign div_tick = ref_tick & at_lim & ~enc_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_q <= 2'b00;
      cnt   <= '0;
    end else begin
      enc_q <= enc_sel;
      if (enc_chg)       cnt <= '0;
      else if (ref_tick) cnt <= at_lim ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sclk_clk_mux.sv
module sclk_clk_mux
  import sclk_pkg::*;
(
  input  logic       pa_rise,
  input  logic       pb_rise,
  input  logic       brg_tick,
  input  logic       pll_rx_tick,
  input  logic       div_tick,
  input  logic [6:0] cmode,
  output logic       rx_en,
  output logic       tx_en,
  output logic       pb_out,
  output logic       pb_oe
);

  logic pb_usable;
  logic pb_pick;

  always_comb begin
    pb_oe     = cmode[CM_OE];
    // A pin that is driven out never serves as an input source.
    pb_usable = pb_rise & ~pb_oe;
    rx_en     = pick4(cmode[CM_RX_HI:CM_RX_LO], {pll_rx_tick, brg_tick, pb_usable, pa_rise});
    tx_en     = pick4(cmode[CM_TX_HI:CM_TX_LO], {div_tick,    brg_tick, pb_usable, pa_rise});
    pb_pick   = pick4(cmode[CM_PB_HI:CM_PB_LO], {pll_rx_tick, brg_tick, rx_en,     tx_en});
    pb_out    = pb_oe & pb_pick;
  end

endmodule

// File: rtl/sclk_route.sv
module sclk_route
  import sclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_FM      = 16,
  parameter int DIV_LVL     = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clkpin_a_in,
  input  logic       clkpin_b_in,
  input  logic       brg_tick,
  input  logic       dpll_rx_tick,
  input  logic       dpll_ref_tick,
  input  logic [6:0] cmode,
  input  logic [1:0] enc_sel,
  output logic       rx_clk_en,
  output logic       tx_clk_en,
  output logic       clkpin_b_out,
  output logic       clkpin_b_oe
);

  localparam int NPINS = 2;
  localparam int DMAX  = (DIV_FM > DIV_LVL) ? DIV_FM : DIV_LVL;
  localparam int CW    = (DMAX > 2) ? $clog2(DMAX) : 1;

  logic [NPINS-1:0] pin_lvl;
  logic [NPINS-1:0] pin_rise;

  // Internal events, named so the checker can observe them.
  logic          pa_rise;
  logic          pb_rise;
  logic          div_tick;
  logic          enc_chg;
  logic [CW-1:0] div_cnt;

  assign pin_lvl = {clkpin_b_in, clkpin_a_in};

  generate
    for (genvar g = 0; g < NPINS; g++) begin : g_pin
      sclk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_lvl (pin_lvl[g]),
        .rise    (pin_rise[g])
      );
    end
  endgenerate

  assign pa_rise = pin_rise[0];
  assign pb_rise = pin_rise[1];

  sclk_txdiv #(.DIV_FM(DIV_FM), .DIV_LVL(DIV_LVL), .CW(CW)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .enc_sel  (enc_sel),
    .ref_tick (dpll_ref_tick),
    .div_tick (div_tick),
    .enc_chg  (enc_chg),
    .cnt      (div_cnt)
  );

  sclk_clk_mux u_mux (
    .pa_rise     (pa_rise),
    .pb_rise     (pb_rise),
    .brg_tick    (brg_tick),
    .pll_rx_tick (dpll_rx_tick),
    .div_tick    (div_tick),
    .cmode       (cmode),
    .rx_en       (rx_clk_en),
    .tx_en       (tx_clk_en),
    .pb_out      (clkpin_b_out),
    .pb_oe       (clkpin_b_oe)
  );

endmodule

// File: rtl/sclk_route_chk.sv
module sclk_route_chk
  import sclk_pkg::*;
#(
  parameter int DIV_FM  = 16,
  parameter int DIV_LVL = 32,
  parameter int CW      = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [6:0]    cmode,
  input logic [1:0]    enc_sel,
  input logic          dpll_ref_tick,
  input logic          dpll_rx_tick,
  input logic          rx_clk_en,
  input logic          tx_clk_en,
  input logic          clkpin_b_out,
  input logic          clkpin_b_oe,
  input logic          div_tick,
  input logic          enc_chg,
  input logic          pa_rise,
  input logic [CW-1:0] div_cnt
);

  // Independent count of reference ticks since the last pulse or coding change.
  logic [CW:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   seen <= '0;
    else if (enc_chg || div_tick) seen <= '0;
    else if (dpll_ref_tick)       seen <= seen + 1'b1;
  end

  // R3 and R4: every pulse closes a full window of ticks.
  assert_div_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
    div_tick |-> (seen == (CW+1)'(div_ratio(enc_sel[1], DIV_FM, DIV_LVL) - 1)));

  assert_enc_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    enc_chg |=> (div_cnt == '0));

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pa_rise |=> !pa_rise);

  assert_tx_divider_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmode[4:3] == 2'b11) |-> (tx_clk_en == div_tick));

  assert_rx_pll_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmode[6:5] == 2'b11) |-> (rx_clk_en == dpll_rx_tick));

  assert_pin_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmode[2] && cmode[6:5] == 2'b01) |-> !rx_clk_en);

  assert_pin_pll_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmode[2] && cmode[1:0] == 2'b11) |-> (clkpin_b_out == dpll_rx_tick));

  assert_pin_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !clkpin_b_oe |-> !clkpin_b_out);

endmodule

bind sclk_route sclk_route_chk #(
  .DIV_FM  (DIV_FM),
  .DIV_LVL (DIV_LVL),
  .CW      (CW)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmode         (cmode),
  .enc_sel       (enc_sel),
  .dpll_ref_tick (dpll_ref_tick),
  .dpll_rx_tick  (dpll_rx_tick),
  .rx_clk_en     (rx_clk_en),
  .tx_clk_en     (tx_clk_en),
  .clkpin_b_out  (clkpin_b_out),
  .clkpin_b_oe   (clkpin_b_oe),
  .div_tick      (div_tick),
  .enc_chg       (enc_chg),
  .pa_rise       (pa_rise),
  .div_cnt       (div_cnt)
);

// File: tb/sclk_route_test.sv
module sclk_route_test;

  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clkpin_a_in = 1'b0;
  logic       clkpin_b_in = 1'b0;
  logic       brg_tick = 1'b0;
  logic       dpll_rx_tick = 1'b0;
  logic       dpll_ref_tick = 1'b0;
  logic [6:0] cmode = '0;
  logic [1:0] enc_sel = 2'b00;
  logic       rx_clk_en, tx_clk_en, clkpin_b_out, clkpin_b_oe;

  sclk_route uut (
    .clk(clk), .rst_n(rst_n), .clkpin_a_in(clkpin_a_in), .clkpin_b_in(clkpin_b_in),
    .brg_tick(brg_tick), .dpll_rx_tick(dpll_rx_tick), .dpll_ref_tick(dpll_ref_tick),
    .cmode(cmode), .enc_sel(enc_sel), .rx_clk_en(rx_clk_en), .tx_clk_en(tx_clk_en),
    .clkpin_b_out(clkpin_b_out), .clkpin_b_oe(clkpin_b_oe)
  );

  // Signal ids: 0 rx_clk_en, 1 tx_clk_en, 2 clkpin_b_out, 3 clkpin_b_oe
  typedef struct {
    int    due;
    string req;
    int    sig;
    logic  val;
  } exp_t;

  exp_t sbq[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  function automatic logic observe(input int sig);
    case (sig)
      0:       return rx_clk_en;
      1:       return tx_clk_en;
      2:       return clkpin_b_out;
      default: return clkpin_b_oe;
    endcase
  endfunction

  // Monitor: pops every item due in this cycle, a quarter period before the rising edge.
  always @(negedge clk) begin
    #(PERIOD/4);
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].due == cyc) begin
        n_chk++;
        if (observe(sbq[i].sig) !== sbq[i].val) begin
          n_fail++;
          $display("FAIL %s signal %0d cycle %0d: actual %b expected %b",
                   sbq[i].req, sbq[i].sig, cyc, observe(sbq[i].sig), sbq[i].val);
        end
        sbq.delete(i);
      end
    end
  end

  // Driver helpers: step to the next cycle with all ticks cleared, and push expectations.
  task automatic nxt();
    @(negedge clk);
    brg_tick = 1'b0;
    dpll_rx_tick = 1'b0;
    dpll_ref_tick = 1'b0;
  endtask

  task automatic want(input int off, input int sig, input logic v, input string r);
    exp_t e;
    e.due = cyc + off; e.req = r; e.sig = sig; e.val = v;
    sbq.push_back(e);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R10: reset state at the ports
    nxt();
    want(0, 0, 1'b0, "R10"); want(0, 1, 1'b0, "R10");
    want(0, 2, 1'b0, "R10"); want(0, 3, 1'b0, "R10");

    // R10: divider starts from zero, level coding, first pulse on tick 32
    nxt(); cmode = 7'b0011000;
    for (int i = 1; i <= 32; i++) begin
      nxt(); dpll_ref_tick = 1'b1;
      want(0, 1, (i == 32), "R10");
    end

    // R1: baud-rate tick on the receive side
    nxt(); cmode = 7'b1000000; brg_tick = 1'b1;
    want(0, 0, 1'b1, "R1");
    nxt(); want(0, 0, 1'b0, "R1");

    // R5 and R3: biphase coding, receive path untouched by the divider
    nxt(); cmode = 7'b1111000; enc_sel = 2'b10;
    nxt();
    for (int i = 1; i <= 16; i++) begin
      nxt(); dpll_ref_tick = 1'b1; dpll_rx_tick = (i == 8);
      want(0, 0, (i == 8), "R5");
      want(0, 1, (i == 16), "R3");
    end
    for (int i = 1; i <= 32; i++) begin
      nxt(); dpll_ref_tick = 1'b1;
      want(0, 1, (i % 16 == 0), "R3");
    end

    // R9: coding change mid-count restarts the window
    for (int i = 1; i <= 10; i++) begin
      nxt(); dpll_ref_tick = 1'b1;
      want(0, 1, 1'b0, "R9");
    end
    nxt(); enc_sel = 2'b11; want(0, 1, 1'b0, "R9");
    for (int i = 1; i <= 16; i++) begin
      nxt(); dpll_ref_tick = 1'b1;
      want(0, 1, (i == 16), "R9");
    end

    // R4: plain level coding divides by 32
    nxt(); enc_sel = 2'b01;
    nxt();
    for (int i = 1; i <= 64; i++) begin
      nxt(); dpll_ref_tick = 1'b1;
      want(0, 1, (i % 32 == 0), "R4");
    end

    // R8: pin A edge timing and single pulse; transmit also on pin A (R2)
    nxt(); cmode = 7'b0000000; clkpin_a_in = 1'b1;
    want(0, 0, 1'b0, "R8"); want(1, 0, 1'b0, "R8"); want(2, 0, 1'b1, "R8");
    want(3, 0, 1'b0, "R8"); want(4, 0, 1'b0, "R8");
    want(2, 1, 1'b1, "R2");
    repeat (5) nxt();
    clkpin_a_in = 1'b0;
    repeat (4) nxt();

    // R2: transmit from pin B while it is an input
    nxt(); cmode = 7'b0001000; clkpin_b_in = 1'b1;
    want(2, 1, 1'b1, "R2"); want(3, 1, 1'b0, "R2");
    repeat (5) nxt();
    clkpin_b_in = 1'b0;
    repeat (4) nxt();

    // R2: transmit from baud-rate tick; receive on pin A stays idle (R1)
    nxt(); cmode = 7'b0010000; brg_tick = 1'b1;
    want(0, 1, 1'b1, "R2"); want(0, 0, 1'b0, "R1");

    // R6: pin B as output is ignored as a source
    nxt(); cmode = 7'b0101100;
    want(0, 3, 1'b1, "R6");
    nxt(); clkpin_b_in = 1'b1;
    want(2, 0, 1'b0, "R6"); want(2, 1, 1'b0, "R6"); want(2, 2, 1'b0, "R6");
    repeat (5) nxt();
    clkpin_b_in = 1'b0;
    repeat (4) nxt();

    // R7: each pin B output source
    nxt(); cmode = 7'b0000110; brg_tick = 1'b1;
    want(0, 2, 1'b1, "R7");
    nxt(); cmode = 7'b0000111; dpll_rx_tick = 1'b1;
    want(0, 2, 1'b1, "R7"); want(0, 0, 1'b0, "R7");
    nxt(); cmode = 7'b1100101; dpll_rx_tick = 1'b1;
    want(0, 2, 1'b1, "R7");
    nxt(); cmode = 7'b0010100; brg_tick = 1'b1;
    want(0, 2, 1'b1, "R7"); want(0, 1, 1'b1, "R2");

    // R7: divider-derived transmit clock appears on pin B
    nxt(); cmode = 7'b0011100;
    for (int i = 1; i <= 32; i++) begin
      nxt(); dpll_ref_tick = 1'b1;
      want(0, 2, (i == 32), "R7");
    end

    // R11: pin B quiet when it is an input
    nxt(); cmode = 7'b0010010; brg_tick = 1'b1;
    want(0, 2, 1'b0, "R11"); want(0, 3, 1'b0, "R11"); want(0, 1, 1'b1, "R2");

    repeat (5) nxt();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule